// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Controller

This block watches a vector of detector status inputs and drives a single active-low interrupt request. Any status bit whose mask bit is clear raises the request when it toggles, in either direction. A second source, a data-ready pulse, raises the request only while an arm bit is set. The request is sticky. It goes away only when the host reads the register belonging to each pending source, or when the block is reset by its hardware reset pin or by a software reset pulse.

The status inputs are asynchronous. They pass through a two-flop synchroniser, and a short warm-up after each reset keeps levels that are already present from counting as changes. A four-state machine tracks which sources are pending. It has the states ST_IDLE (nothing pending), ST_CHG (a status change is pending), ST_DATA (data-ready is pending) and ST_BOTH (both are pending).

Its transitions are as follows. A set event takes a source from absent to present: IDLE to CHG, IDLE to DATA, CHG to BOTH, DATA to BOTH. The matching read takes it back: CHG to IDLE, DATA to IDLE, BOTH to DATA, BOTH to CHG. A software reset returns any state to IDLE. A set event that arrives in the same cycle as the clearing read wins, so no event is lost.

The pin driver gives either a push-pull output or an open-drain style enable.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After hardware reset, irq_n is 1, status_rdata is 0, and irq_oe is 1 when od_mode is 0.
- R2: A 0-to-1 change on an unmasked status_in bit drives irq_n to 0 on the third rising clock edge after the new level is applied.
- R3: A 1-to-0 change on an unmasked status_in bit likewise drives irq_n to 0 on the third rising edge.
- R4: A status_in bit whose mask_bits bit is 1 cannot raise the interrupt, in either direction of change.
- R5: A one-cycle txd_new pulse drives irq_n to 0 at the next rising edge when arm_txd is 1. When arm_txd is 0 the pulse is ignored.
- R6: Once irq_n is 0 it stays 0 even after the status input returns to its earlier level, until the clearing read or a reset.
- R7: A rd_status pulse clears a pending status change, and a rd_txd pulse clears pending data-ready. irq_n returns to 1 only when no source is left pending.
- R8: An unmasked change whose detection coincides with a rd_status pulse keeps the change source pending, so irq_n stays 0.
- R9: On a rd_status pulse, status_rdata captures the synchronised status vector, visible after that rising edge.
- R10: With od_mode at 1, irq_oe is 1 exactly while the interrupt is asserted. With od_mode at 0, irq_oe is always 1.
- R11: A sw_reset pulse clears all pending sources, and irq_n is 1 after that rising edge.
- R12: Status levels present while a reset is released do not raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset pulse |
| status_in | input | W | Asynchronous detector status bits |
| mask_bits | input | W | Per-bit mask; 1 blocks that bit |
| arm_txd | input | 1 | Arms the data-ready source |
| txd_new | input | 1 | One-cycle new-transmit-data pulse |
| rd_status | input | 1 | Host read strobe of the status register |
| rd_txd | input | 1 | Host read strobe of the transmit data register |
| od_mode | input | 1 | 1 selects open-drain enable behaviour |
| irq_n | output | 1 | Interrupt request, active low |
| irq_oe | output | 1 | Output enable for the interrupt pin |
| status_rdata | output | W | Status snapshot captured by the last read |

## Verification
The bench aims a change at exactly the cycle in which a status read takes effect. A design that let the clear win over the set would drop that change and release irq_n. It toggles a bit and then returns it to its old level before any read, which catches a design that compares levels instead of latching edges. It also releases reset with non-zero status inputs. A design without a warm-up would raise a spurious interrupt there. Finally, it checks that one read leaves the other source pending, and that an unarmed data pulse leaves nothing behind. A design that merged the sources or latched unarmed pulses would show irq_n low where it must be high.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CHG  = 2'd1,
        ST_DATA = 2'd2,
        ST_BOTH = 2'd3
    } irq_state_e;

    localparam int unsigned WARM_CYCLES = 3;
endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_reset,
    input  logic [W-1:0] status_in,
    input  logic [W-1:0] mask_bits,
    output logic [W-1:0] status_sync,
    output logic         chg_evt
);
    import chg_irq_pkg::*;
    localparam int unsigned CW = $clog2(WARM_CYCLES + 1);

    logic [W-1:0]  meta_q;
    logic [W-1:0]  sync_q;
    logic [W-1:0]  prev_q;
    logic [CW-1:0] warm_q;
    logic          warm_done;
    logic [W-1:0]  bit_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
            warm_q <= '0;
        end else if (sw_reset) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
            warm_q <= '0;
        end else begin
            meta_q <= status_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (!warm_done)
                warm_q <= warm_q + 1'b1;
        end
    end

    assign warm_done = (warm_q == CW'(WARM_CYCLES));

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_evt[i] = (sync_q[i] ^ prev_q[i]) & ~mask_bits[i];
    end

    assign chg_evt     = warm_done & (|bit_evt);
    assign status_sync = sync_q;
endmodule

// File: rtl/chg_irq_fsm.sv
module chg_irq_fsm (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sw_reset,
    input  logic                    set_chg,
    input  logic                    clr_chg,
    input  logic                    set_dat,
    input  logic                    clr_dat,
    output chg_irq_pkg::irq_state_e state,
    output logic                    asserted
);
    import chg_irq_pkg::*;

    irq_state_e state_q, state_d;
    logic chg_p, dat_p, chg_n, dat_n;

    always_comb begin
        chg_p = 1'b0;
        dat_p = 1'b0;
        unique case (state_q)
            ST_IDLE: begin chg_p = 1'b0; dat_p = 1'b0; end
            ST_CHG:  begin chg_p = 1'b1; dat_p = 1'b0; end
            ST_DATA: begin chg_p = 1'b0; dat_p = 1'b1; end
            ST_BOTH: begin chg_p = 1'b1; dat_p = 1'b1; end
        endcase
        chg_n = set_chg | (chg_p & ~clr_chg);
        dat_n = set_dat | (dat_p & ~clr_dat);
        unique case ({chg_n, dat_n})
            2'b00: state_d = ST_IDLE;
            2'b10: state_d = ST_CHG;
            2'b01: state_d = ST_DATA;
            2'b11: state_d = ST_BOTH;
        endcase
        if (sw_reset)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        asserted = (state_q != ST_IDLE);
    end

    assign state = state_q;
endmodule

// File: rtl/chg_irq_pin.sv
module chg_irq_pin (
    input  logic asserted,
    input  logic od_mode,
    output logic irq_n,
    output logic irq_oe
);
    always_comb begin
        irq_n  = ~asserted;
        irq_oe = od_mode ? asserted : 1'b1;
    end
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_reset,
    input  logic [W-1:0] status_in,
    input  logic [W-1:0] mask_bits,
    input  logic         arm_txd,
    input  logic         txd_new,
    input  logic         rd_status,
    input  logic         rd_txd,
    input  logic         od_mode,
    output logic         irq_n,
    output logic         irq_oe,
    output logic [W-1:0] status_rdata
);
    import chg_irq_pkg::*;

    logic [W-1:0] status_sync;
    logic         chg_evt;
    logic         data_evt;
    logic         asserted;
    irq_state_e   state;
    logic [W-1:0] rdata_q;

    chg_irq_sync #(.W(W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_reset   (sw_reset),
        .status_in  (status_in),
        .mask_bits  (mask_bits),
        .status_sync(status_sync),
        .chg_evt    (chg_evt)
    );

    assign data_evt = txd_new & arm_txd;

    chg_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_reset(sw_reset),
        .set_chg (chg_evt),
        .clr_chg (rd_status),
        .set_dat (data_evt),
        .clr_dat (rd_txd),
        .state   (state),
        .asserted(asserted)
    );

    chg_irq_pin u_pin (
        .asserted(asserted),
        .od_mode (od_mode),
        .irq_n   (irq_n),
        .irq_oe  (irq_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (sw_reset)
            rdata_q <= '0;
        else if (rd_status)
            rdata_q <= status_sync;
    end

    assign status_rdata = rdata_q;
endmodule

// File: rtl/chg_irq_ctrl_chk.sv
module chg_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_reset,
    input logic arm_txd,
    input logic txd_new,
    input logic rd_status,
    input logic rd_txd,
    input logic od_mode,
    input logic chg_evt,
    input logic irq_n,
    input logic irq_oe
);
    // R2
    fall_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n)) |-> $past(chg_evt || (txd_new && arm_txd)));

    // R6
    sticky_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !rd_status && !rd_txd && !sw_reset) |=> !irq_n);

    // R7
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && rd_txd && !chg_evt && !(txd_new && arm_txd) && !sw_reset) |=> irq_n);

    // R8
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_evt && rd_status && !sw_reset) |=> !irq_n);

    // R10
    od_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_mode && irq_n) |-> !irq_oe);

    // R11
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> irq_n);
endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_reset (sw_reset),
    .arm_txd  (arm_txd),
    .txd_new  (txd_new),
    .rd_status(rd_status),
    .rd_txd   (rd_txd),
    .od_mode  (od_mode),
    .chg_evt  (chg_evt),
    .irq_n    (irq_n),
    .irq_oe   (irq_oe)
);

// File: tb/chg_irq_ctrl_test.sv
module chg_irq_ctrl_test;
    localparam int W = 8;
    localparam int NV = 14;

    // {status, mask, arm, txd_new, rd_status, rd_txd, exp_irq_n}
    typedef struct packed {
        logic [7:0] st;
        logic [7:0] mk;
        logic       arm;
        logic       txd;
        logic       rds;
        logic       rdt;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R1 idle
        '{8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 rise
        '{8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 read clears
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 fall
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7
        '{8'h10, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 masked rise
        '{8'h00, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 masked fall
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R5 unarmed
        '{8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 armed
        '{8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 wrong read
        '{8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 data read
        '{8'h02, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 both
        '{8'h02, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 data left
        '{8'h02, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}   // R7 none left
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_reset = 1'b0;
    logic [W-1:0] status_in = '0;
    logic [W-1:0] mask_bits = '0;
    logic         arm_txd = 1'b0;
    logic         txd_new = 1'b0;
    logic         rd_status = 1'b0;
    logic         rd_txd = 1'b0;
    logic         od_mode = 1'b0;
    logic         irq_n;
    logic         irq_oe;
    logic [W-1:0] status_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    chg_irq_ctrl #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .status_in(status_in), .mask_bits(mask_bits),
        .arm_txd(arm_txd), .txd_new(txd_new),
        .rd_status(rd_status), .rd_txd(rd_txd), .od_mode(od_mode),
        .irq_n(irq_n), .irq_oe(irq_oe), .status_rdata(status_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R12: non-zero levels during reset release
        status_in = 8'hA5;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 irq_oe", irq_oe, 1);
        chk("R1 rdata", status_rdata, 0);
        edges(6);
        chk("R12 hw reset levels", irq_n, 1);
        @(negedge clk); status_in = 8'h00;
        edges(4);
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
        edges(1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            status_in = VECS[v].st; mask_bits = VECS[v].mk; arm_txd = VECS[v].arm;
            txd_new = VECS[v].txd; rd_status = VECS[v].rds; rd_txd = VECS[v].rdt;
            @(negedge clk);
            txd_new = 1'b0; rd_status = 1'b0; rd_txd = 1'b0;
            edges(3);
            chk($sformatf("R2-table v%0d", v), irq_n, VECS[v].exp);
        end

        // R6: toggle and return before any read
        @(negedge clk); status_in = 8'h06;
        edges(4);
        @(negedge clk); status_in = 8'h02;
        edges(5);
        chk("R6 sticky", irq_n, 0);

        // R8 / R9: change detected in the read cycle
        @(negedge clk); status_in = 8'h0A;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
        #1;
        chk("R8 coincide", irq_n, 0);
        chk("R9 rdata", status_rdata, 8'h0A);
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
        edges(1);
        chk("R8 second read", irq_n, 1);

        // R10: open-drain enable
        @(negedge clk); od_mode = 1'b1; #1;
        chk("R10 float", irq_oe, 0);
        @(negedge clk); txd_new = 1'b1;
        @(negedge clk); txd_new = 1'b0; #1;
        chk("R5 armed pulse", irq_n, 0);
        chk("R10 drive", irq_oe, 1);
        @(negedge clk); od_mode = 1'b0; #1;
        chk("R10 push-pull", irq_oe, 1);

        // R11 / R12: software reset with non-zero levels
        @(negedge clk); status_in = 8'h3C; sw_reset = 1'b1;
        @(negedge clk); sw_reset = 1'b0; #1;
        chk("R11 sw reset", irq_n, 1);
        edges(6);
        chk("R12 sw reset levels", irq_n, 1);
        chk("R11 rdata cleared", status_rdata, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule